// File: doc/BRIEF.md
# Frame Push Streamer with Pre-Frame Command List

This block pushes one complete frame to a parallel display controller each time its run control goes from low to high. The frame opens with a short list of command-list slots, played out in slot order. Each slot becomes either a command-port write or a data-port write. The pixel raster follows, fetched from a frame-buffer read port. Every beat leaves on a single valid/ready request channel, which normally feeds a bus timing engine. That engine tells command writes from data writes by a tag bit.

Pixels are RGB565 and are addressed row by row. A row starts at a programmed base address, and each new row adds a programmed byte pitch. Any position outside the programmed layer rectangle is sent as a programmable background colour, and so is every position when the layer is switched off. Those positions cause no memory read. On an 8-bit display path each pixel is sent as two byte writes. On a 16-bit path it is sent as one write.

Software writes the slot store and the configuration inputs, then drops run and raises it again to send the next frame. The slot count, the path width, the frame geometry and the background colour are captured when the frame starts. After the final beat of the frame has been accepted, a one-cycle done pulse is raised and the block waits for the next rising edge of run.

Top module: `frame_list_streamer`

## Requirements
- R1: After a synchronous reset, `out_valid`, `fb_rd_en` and `frame_done` are all low.
- R2: A frame begins only on a rising edge of `run` while the block is idle. Holding `run` high after a frame has completed produces no further beats and no further done pulse.
- R3: With `list_en` high, slots 0 to `list_last` (the slot count minus one) are sent in increasing index order, before any pixel. Slot bit 23 set gives a command write (`out_is_cmd`=1); bit 23 clear gives a data write. `out_data` carries the slot's bits 15:0.
- R4: With `list_en` low, no slot is sent and the frame starts with its first pixel.
- R5: Pixels are sent row by row, each row from x=0 upward. A pixel inside the layer is read from byte address `base_addr + y*pitch_bytes + 2*x`. Exactly one read is issued per pixel inside the layer.
- R6: A pixel with x ≥ layer width or y ≥ layer height, or any pixel while `layer_en` is low, is sent as `bg_color` and issues no read.
- R7: With `narrow` high, each pixel goes out as two data writes, high byte first, each carried in `out_data[7:0]` with `out_data[15:8]`=0. With `narrow` low, each pixel is a single 16-bit data write.
- R8: `frame_done` pulses for exactly one cycle, in the cycle after the last beat of the frame is accepted. A frame with zero width or zero height sends only its slots (if enabled) and then signals done.
- R9: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` and `out_is_cmd` unchanged.
- R10: `frame_size` and `layer_size` each carry height in bits 31:16 and width in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Frame start control, acts on its rising edge |
| list_en | input | 1 | Send the command list before the pixels |
| layer_en | input | 1 | Take pixels from the frame buffer, otherwise background only |
| narrow | input | 1 | 1: 8-bit display path, 0: 16-bit path |
| list_last | input | LIST_AW | Number of slots minus one |
| frame_size | input | 32 | Frame height [31:16], width [15:0] |
| layer_size | input | 32 | Layer height [31:16], width [15:0] |
| pitch_bytes | input | 16 | Row stride in bytes |
| base_addr | input | ADDR_W | Byte address of layer pixel (0,0) |
| bg_color | input | 16 | RGB565 colour for positions outside the layer |
| list_wr_en | input | 1 | Write strobe for the slot store |
| list_wr_idx | input | LIST_AW | Slot index to write |
| list_wr_data | input | 32 | Slot word: bit 23 command flag, bits 15:0 value |
| fb_rd_en | output | 1 | Frame-buffer read request |
| fb_rd_addr | output | ADDR_W | Frame-buffer byte address |
| fb_rd_data | input | 16 | Read data, valid the cycle after the request |
| out_valid | output | 1 | Downstream write request valid |
| out_ready | input | 1 | Downstream accepts the request |
| out_is_cmd | output | 1 | 1: command-port write, 0: data-port write |
| out_data | output | 16 | Write value |
| frame_done | output | 1 | One-cycle pulse after the frame's last accepted beat |

## Verification
The assertions check on every cycle that a stalled request holds its value (R9), that done is a single-cycle pulse with nothing in flight (R8), that the slot index never passes the programmed last slot, that the pixel scan never steps outside the frame, and that pixel bytes on the narrow path keep the upper byte clear. Only the bench scenarios can show the complete ordering of each frame: the slot sequence, the raster order with its addresses, where the background is substituted, and the number of reads issued. The bench compares these, beat for beat, against a model of the requirements, over directed geometries (layer switched off, list switched off, zero width, a single pixel) and over random shapes with random back-pressure.

// File: rtl/fs_pkg.sv
`timescale 1ns/1ps
package fs_pkg;

    localparam int VAL_W        = 16;
    localparam int DIM_W        = 16;
    localparam int SLOT_W       = 32;
    localparam int CMD_FLAG_BIT = 23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIST,
        ST_FETCH,
        ST_WAIT,
        ST_HI,
        ST_LO
    } fs_state_e;

    typedef struct packed {
        logic             is_cmd;
        logic [VAL_W-1:0] value;
    } fs_beat_t;

    typedef struct packed {
        logic [DIM_W-1:0] h;
        logic [DIM_W-1:0] w;
    } fs_dims_t;

    function automatic fs_beat_t slot_to_beat(input logic [SLOT_W-1:0] word);
        fs_beat_t b;
        b.is_cmd = word[CMD_FLAG_BIT];
        b.value  = word[VAL_W-1:0];
        return b;
    endfunction

    function automatic fs_dims_t unpack_dims(input logic [SLOT_W-1:0] word);
        return fs_dims_t'(word);
    endfunction

    function automatic logic dims_empty(input logic [SLOT_W-1:0] word);
        fs_dims_t d;
        d = unpack_dims(word);
        return (d.w == '0) || (d.h == '0);
    endfunction

    function automatic logic [VAL_W-1:0] byte_lane(input logic [VAL_W-1:0] px,
                                                   input logic upper);
        return upper ? {8'h00, px[15:8]} : {8'h00, px[7:0]};
    endfunction

endpackage

// File: rtl/fs_cmd_list.sv
`timescale 1ns/1ps
module fs_cmd_list
    import fs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output fs_beat_t          rd_beat
);

    logic [SLOT_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_beat = slot_to_beat(slots[rd_idx]);

endmodule

// File: rtl/fs_scan.sv
`timescale 1ns/1ps
module fs_scan
    import fs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [SLOT_W-1:0] frame_size,
    input  logic [SLOT_W-1:0] layer_size,
    input  logic              layer_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DIM_W-1:0]  pitch_bytes,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              in_layer,
    output logic              at_last
);

    fs_dims_t          frame_q;
    fs_dims_t          layer_q;
    logic              len_q;
    logic [DIM_W-1:0]  pitch_q;
    logic [DIM_W-1:0]  x_q;
    logic [DIM_W-1:0]  y_q;
    logic [ADDR_W-1:0] row_q;
    logic              row_end;

    assign row_end  = (x_q == frame_q.w - 1'b1);
    assign at_last  = row_end && (y_q == frame_q.h - 1'b1);
    assign in_layer = len_q && (x_q < layer_q.w) && (y_q < layer_q.h);
    assign pix_addr = row_q + (ADDR_W'(x_q) << 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            layer_q <= '0;
            len_q   <= 1'b0;
            pitch_q <= '0;
            x_q     <= '0;
            y_q     <= '0;
            row_q   <= '0;
        end else if (load) begin
            frame_q <= unpack_dims(frame_size);
            layer_q <= unpack_dims(layer_size);
            len_q   <= layer_en;
            pitch_q <= pitch_bytes;
            x_q     <= '0;
            y_q     <= '0;
            row_q   <= base_addr;
        end else if (step) begin
            if (row_end) begin
                x_q   <= '0;
                y_q   <= y_q + 1'b1;
                row_q <= row_q + ADDR_W'(pitch_q);
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    // R5: the scan never advances from a position outside the frame
    a_r5_step_in_frame: assert property (@(posedge clk) disable iff (rst)
        step |-> (x_q < frame_q.w) && (y_q < frame_q.h));

endmodule

// File: rtl/frame_list_streamer.sv
`timescale 1ns/1ps
module frame_list_streamer
    import fs_pkg::*;
#(
    parameter int LIST_DEPTH = 16,
    parameter int ADDR_W     = 32,
    localparam int LIST_AW   = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               list_en,
    input  logic               layer_en,
    input  logic               narrow,
    input  logic [LIST_AW-1:0] list_last,
    input  logic [31:0]        frame_size,
    input  logic [31:0]        layer_size,
    input  logic [15:0]        pitch_bytes,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [15:0]        bg_color,
    input  logic               list_wr_en,
    input  logic [LIST_AW-1:0] list_wr_idx,
    input  logic [31:0]        list_wr_data,
    output logic               fb_rd_en,
    output logic [ADDR_W-1:0]  fb_rd_addr,
    input  logic [15:0]        fb_rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_is_cmd,
    output logic [15:0]        out_data,
    output logic               frame_done
);

    fs_state_e          state_q;
    logic               run_q;
    logic [LIST_AW-1:0] idx_q;
    logic [LIST_AW-1:0] last_q;
    logic               narrow_q;
    logic               empty_q;
    logic [VAL_W-1:0]   bg_q;
    logic [VAL_W-1:0]   pix_q;
    logic               done_q;

    logic               start;
    logic               accept;
    logic               pix_finish;
    logic               scan_step;
    logic               scan_in_layer;
    logic               scan_last;
    fs_beat_t           slot_beat;
    fs_beat_t           beat;

    assign start  = run && !run_q && (state_q == ST_IDLE);
    assign accept = out_valid && out_ready;

    // The final beat of a pixel is being accepted
    assign pix_finish = accept &&
                        (((state_q == ST_HI) && !narrow_q) || (state_q == ST_LO));
    assign scan_step  = pix_finish && !scan_last;

    fs_cmd_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk     (clk),
        .wr_en   (list_wr_en),
        .wr_idx  (list_wr_idx),
        .wr_data (list_wr_data),
        .rd_idx  (idx_q),
        .rd_beat (slot_beat)
    );

    fs_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .load        (start),
        .step        (scan_step),
        .frame_size  (frame_size),
        .layer_size  (layer_size),
        .layer_en    (layer_en),
        .base_addr   (base_addr),
        .pitch_bytes (pitch_bytes),
        .pix_addr    (fb_rd_addr),
        .in_layer    (scan_in_layer),
        .at_last     (scan_last)
    );

    assign fb_rd_en = (state_q == ST_FETCH) && scan_in_layer;

    always_comb begin
        beat      = '0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_LIST: begin
                out_valid = 1'b1;
                beat      = slot_beat;
            end
            ST_HI: begin
                out_valid    = 1'b1;
                beat.is_cmd  = 1'b0;
                beat.value   = narrow_q ? byte_lane(pix_q, 1'b1) : pix_q;
            end
            ST_LO: begin
                out_valid    = 1'b1;
                beat.is_cmd  = 1'b0;
                beat.value   = byte_lane(pix_q, 1'b0);
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign out_is_cmd = beat.is_cmd;
    assign out_data   = beat.value;
    assign frame_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            run_q    <= 1'b0;
            idx_q    <= '0;
            last_q   <= '0;
            narrow_q <= 1'b0;
            empty_q  <= 1'b0;
            bg_q     <= '0;
            pix_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            run_q  <= run;
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q    <= '0;
                        last_q   <= list_last;
                        narrow_q <= narrow;
                        empty_q  <= dims_empty(frame_size);
                        bg_q     <= bg_color;
                        if (list_en) begin
                            state_q <= ST_LIST;
                        end else if (dims_empty(frame_size)) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_LIST: begin
                    if (accept) begin
                        if (idx_q == last_q) begin
                            if (empty_q) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_FETCH;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (scan_in_layer) begin
                        state_q <= ST_WAIT;
                    end else begin
                        pix_q   <= bg_q;
                        state_q <= ST_HI;
                    end
                end
                ST_WAIT: begin
                    pix_q   <= fb_rd_data;
                    state_q <= ST_HI;
                end
                ST_HI, ST_LO: begin
                    if (accept && (state_q == ST_HI) && narrow_q) begin
                        state_q <= ST_LO;
                    end else if (pix_finish) begin
                        if (scan_last) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a stalled request keeps its content
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_cmd));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R8: nothing is in flight while done is raised
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !out_valid && !fb_rd_en);

    // R3: the slot index stays within the programmed list
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LIST) |-> (idx_q <= last_q));

    // R7: pixel bytes on the narrow path keep the upper byte clear
    a_r7_narrow_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid && narrow_q && (state_q == ST_HI || state_q == ST_LO)
        |-> (out_data[15:8] == 8'h00));

    // R5: a read is followed by the capture cycle
    a_r5_read_then_capture: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |=> (state_q == ST_WAIT) && !out_valid);

endmodule

// File: tb/frame_list_streamer_test.sv
`timescale 1ns/1ps
module frame_list_streamer_test;

    localparam int LA = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        list_en = 1'b0;
    logic        layer_en = 1'b0;
    logic        narrow = 1'b0;
    logic [LA-1:0] list_last = '0;
    logic [31:0] frame_size = '0;
    logic [31:0] layer_size = '0;
    logic [15:0] pitch_bytes = '0;
    logic [31:0] base_addr = '0;
    logic [15:0] bg_color = '0;
    logic        list_wr_en = 1'b0;
    logic [LA-1:0] list_wr_idx = '0;
    logic [31:0] list_wr_data = '0;
    logic        fb_rd_en;
    logic [31:0] fb_rd_addr;
    logic [15:0] fb_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_is_cmd;
    logic [15:0] out_data;
    logic        frame_done;

    frame_list_streamer #(.LIST_DEPTH(16), .ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .run(run), .list_en(list_en), .layer_en(layer_en),
        .narrow(narrow), .list_last(list_last), .frame_size(frame_size),
        .layer_size(layer_size), .pitch_bytes(pitch_bytes), .base_addr(base_addr),
        .bg_color(bg_color), .list_wr_en(list_wr_en), .list_wr_idx(list_wr_idx),
        .list_wr_data(list_wr_data), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_is_cmd(out_is_cmd), .out_data(out_data), .frame_done(frame_done)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [16:0] rx_q  [0:1023];
    logic [16:0] exp_q [0:1023];
    logic [31:0] slot  [0:15];
    int rx_n = 0;
    int done_cnt = 0;
    int done_at = 0;
    int rd_cnt = 0;
    int stall_err = 0;
    bit monitor_on = 1'b0;
    int ready_pct = 70;

    function automatic logic [15:0] fbval(input logic [31:0] a);
        logic [15:0] t;
        t = a[15:0] * 16'h9E37;
        return t ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Downstream and frame-buffer model, sampled between edges
    initial begin
        bit       held_v;
        logic [16:0] held;
        held_v = 1'b0;
        held   = '0;
        forever begin
            @(negedge clk);
            out_ready = (($urandom % 100) < ready_pct);
            #1;
            if (monitor_on) begin
                if (held_v && !(out_valid && {out_is_cmd, out_data} == held)) stall_err++;
                held_v = out_valid && !out_ready;
                held   = {out_is_cmd, out_data};
                if (out_valid && out_ready && rx_n < 1024) begin
                    rx_q[rx_n] = {out_is_cmd, out_data};
                    rx_n++;
                end
                if (frame_done) begin
                    done_cnt++;
                    done_at = rx_n;
                end
                if (fb_rd_en) begin
                    fb_rd_data = fbval(fb_rd_addr);
                    rd_cnt++;
                end
            end else begin
                held_v = 1'b0;
            end
        end
    end

    task automatic run_frame(input string tag, input bit nar, input bit lst, input bit lay,
                             input int last, input int w, input int h, input int lw,
                             input int lh, input int pitch, input logic [31:0] base,
                             input logic [15:0] bg);
        int exp_n;
        int exp_rd;
        int mism;
        int rx_snap;
        int wait_cyc;
        logic [15:0] px;
        logic [31:0] a;
        @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 16; i++) begin
            slot[i] = $urandom;
            @(negedge clk);
            list_wr_en   = 1'b1;
            list_wr_idx  = LA'(i);
            list_wr_data = slot[i];
        end
        @(negedge clk);
        list_wr_en  = 1'b0;
        narrow      = nar;
        list_en     = lst;
        layer_en    = lay;
        list_last   = LA'(last);
        frame_size  = {16'(h), 16'(w)};   // R10: height high half, width low half
        layer_size  = {16'(lh), 16'(lw)};
        pitch_bytes = 16'(pitch);
        base_addr   = base;
        bg_color    = bg;
        exp_n  = 0;
        exp_rd = 0;
        if (lst) begin
            for (int i = 0; i <= last; i++) begin
                exp_q[exp_n] = {slot[i][23], slot[i][15:0]};
                exp_n++;
            end
        end
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                if (lay && x < lw && y < lh) begin
                    a  = base + 32'(y) * 32'(pitch) + 32'(2 * x);
                    px = fbval(a);
                    exp_rd++;
                end else begin
                    px = bg;
                end
                if (nar) begin
                    exp_q[exp_n] = {1'b0, 8'h00, px[15:8]};
                    exp_q[exp_n + 1] = {1'b0, 8'h00, px[7:0]};
                    exp_n += 2;
                end else begin
                    exp_q[exp_n] = {1'b0, px};
                    exp_n++;
                end
            end
        end
        rx_n = 0; done_cnt = 0; done_at = 0; rd_cnt = 0; stall_err = 0;
        monitor_on = 1'b1;
        @(negedge clk);
        run = 1'b1;
        wait_cyc = 0;
        while (done_cnt == 0 && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (done_cnt == 0) check(1'b0, "R8", "frame watchdog expired", 0, 1);
        rx_snap = rx_n;
        repeat (20) @(negedge clk);
        #2;
        mism = -1;
        for (int i = 0; i < exp_n; i++) begin
            if (mism < 0 && rx_q[i] !== exp_q[i]) mism = i;
        end
        if (mism >= 0) begin
            check(1'b0, tag, (mism < (lst ? last + 1 : 0)) ? "R3 slot beat" : "R5/R6/R7 pixel beat",
                  longint'(rx_q[mism]), longint'(exp_q[mism]));
        end else begin
            check(rx_snap == exp_n, tag, "beat count", rx_snap, exp_n);
        end
        check(done_cnt == 1 && done_at == exp_n, "R8", "done pulse after last beat", done_at, exp_n);
        check(rx_n == rx_snap && done_cnt == 1, "R2", "no restart while run held", rx_n, rx_snap);
        check(rd_cnt == exp_rd, "R5", "frame-buffer read count", rd_cnt, exp_rd);
        check(stall_err == 0, "R9", "request held under stall", stall_err, 0);
        monitor_on = 1'b0;
        run = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(fb_rd_en == 1'b0, "R1", "fb_rd_en in reset", fb_rd_en, 0);
        check(frame_done == 1'b0, "R1", "frame_done in reset", frame_done, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && frame_done == 1'b0, "R1", "idle after reset", out_valid, 0);

        // R3 and R7: narrow path, full layer, three slots
        run_frame("R3", 1'b1, 1'b1, 1'b1, 2, 4, 3, 4, 3, 8, 32'h1000, 16'hF81F);
        // R6: layer smaller than frame, wide path, padded pitch
        run_frame("R6", 1'b0, 1'b1, 1'b1, 1, 5, 2, 3, 1, 12, 32'h2002, 16'h07E0);
        // R6: layer disabled, all background
        run_frame("R6", 1'b1, 1'b1, 1'b0, 0, 3, 2, 3, 2, 6, 32'h3000, 16'h1234);
        // R4: list disabled
        run_frame("R4", 1'b0, 1'b0, 1'b1, 5, 3, 3, 3, 3, 6, 32'h0400, 16'h0000);
        // R8: zero-width frame sends only the slots
        run_frame("R8", 1'b0, 1'b1, 1'b1, 3, 0, 4, 2, 2, 4, 32'h0000, 16'hFFFF);
        // R8: zero-height frame without list
        run_frame("R8", 1'b1, 1'b0, 1'b1, 0, 4, 0, 4, 4, 8, 32'h0000, 16'hAAAA);
        // R7: single pixel, single slot, narrow
        run_frame("R7", 1'b1, 1'b1, 1'b1, 0, 1, 1, 1, 1, 2, 32'h0777, 16'h0000);
        // R10: tall thin frame shows height/width packing
        run_frame("R10", 1'b0, 1'b1, 1'b1, 15, 2, 5, 2, 4, 4, 32'h8000, 16'hBEEF);
        ready_pct = 100;
        run_frame("R5", 1'b1, 1'b1, 1'b1, 4, 5, 4, 5, 4, 10, 32'h0100, 16'h0F0F);
        ready_pct = 40;
        for (int k = 0; k < 10; k++) begin
            int w;
            int h;
            w = int'($urandom % 6);
            h = int'($urandom % 5);
            run_frame("R5", 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 != 0),
                      int'($urandom % 16), w, h, int'($urandom % 7), int'($urandom % 6),
                      w * 2 + 2 * int'($urandom % 4), $urandom & 32'hFFFF_FFFE,
                      16'($urandom));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 global watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule